// File: doc/BRIEF.md
# CAN Two-Stage Receive Message Store

This block keeps received CAN frames in a two-deep queue made of a hidden capture buffer and a buffer that software can read. The bit-level receive engine writes the 13 bytes of a frame image (control bits, standard or extended identifier, payload) by index into the capture buffer. In parallel, an identifier acceptance check compares the presented identifier with a code and a mask. When the end-of-frame strobe arrives with a good CRC and the identifier was accepted, the image is copied into the readable buffer, the receiver-full flag rises and a level interrupt is raised if it is enabled.

Software always reads received data through a single 13-entry byte window, which shows the readable buffer only. It acknowledges a frame by writing one to the receiver-full bit, and this frees the readable buffer. A frame accepted while that buffer is still occupied waits in the capture buffer and is promoted on the clock after the flag clears. A third accepted frame that arrives while one is already waiting is dropped, and a sticky overrun flag records the loss.

Top module: `can_rx_dualbuf`

## Requirements
- R1: After reset, rxf, ovr and irq are 0, no frame is pending, and every byte of the read window reads 0x00.
- R2: A cycle with rx_wr_en high stores rx_wr_data into capture byte rx_wr_idx (valid indices 0 to 12). An index of 13 or above is ignored. Capture writes never change the read window until a promotion.
- R3: In a cycle with rx_id_vld high, the 29-bit rx_id is judged accepted when ((rx_id XOR acc_code) AND NOT acc_mask) is zero, so mask bits that are 1 are don't-care. The verdict is held until the next rx_eof, which clears it.
- R4: An rx_eof cycle with rx_crc_ok high, an accepted identifier, rxf at 0 and nothing pending copies the capture image to the read window at that clock edge and sets rxf.
- R5: rd_data combinationally shows byte rd_idx of the readable buffer. rd_idx of 13 or above reads 0x00.
- R6: While rxf is 1, the read window contents do not change.
- R7: A cycle with clr_wr high and clr_data[0] = 1 clears rxf. A cycle with clr_data[0] = 0 leaves rxf unchanged.
- R8: An rx_eof with rx_crc_ok low, or with a rejected identifier, leaves rxf, ovr, the pending state and the read window unchanged.
- R9: An accepted frame that ends while rxf is 1 becomes pending, and capture writes are ignored while it is pending. It is promoted, and rxf is set, at the first clock edge at which rxf is 0 and the frame is still pending.
- R10: An accepted frame that ends while another frame is pending is dropped and sets ovr. ovr stays set until a cycle with clr_wr high and clr_data[1] = 1. If a set and a clear fall in the same cycle, the set wins, and the same rule applies to rxf.
- R11: irq equals rxf AND rie at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_wr_en | input | 1 | Capture byte write strobe |
| rx_wr_idx | input | 4 | Capture byte index |
| rx_wr_data | input | 8 | Capture byte value |
| rx_id_vld | input | 1 | Identifier valid for acceptance check |
| rx_id | input | 29 | Frame identifier |
| rx_eof | input | 1 | End-of-frame strobe |
| rx_crc_ok | input | 1 | CRC good, qualified by rx_eof |
| acc_code | input | 29 | Acceptance code |
| acc_mask | input | 29 | Acceptance mask, 1 = don't care |
| rie | input | 1 | Receive interrupt enable |
| clr_wr | input | 1 | Flag clear write strobe |
| clr_data | input | 2 | Write-one-to-clear bits: [0] rxf, [1] ovr |
| rd_idx | input | 4 | Read window byte index |
| rd_data | output | 8 | Read window byte |
| rxf | output | 1 | Receiver full flag |
| ovr | output | 1 | Overrun flag |
| irq | output | 1 | Receive interrupt, level |

## Verification
A wrong pending bit shows up on the clock after software clears rxf: rxf either fails to rise again or rises with no frame waiting, and the window then shows old or spurious bytes. A corrupted capture buffer or a wrong promotion shows as a byte mismatch in the read window the first time that index is swept after the promotion. A wrong acceptance verdict or a wrong flag priority changes rxf or ovr one clock after the rx_eof or clear cycle concerned. The bench compares every output against a behavioural model on every clock, sweeping rd_idx over the window and past its end, so each of these faults is reported within a few cycles.

// File: rtl/can_rx_pkg.sv
package can_rx_pkg;

   typedef logic [7:0] byte_t;

   // outcome of a frame end, decided in the flag controller
   typedef enum logic [1:0] {
      EV_NONE = 2'd0,
      EV_LOAD = 2'd1,
      EV_PEND = 2'd2,
      EV_DROP = 2'd3
   } rx_event_e;

endpackage

// File: rtl/can_rx_accept.sv
module can_rx_accept #(
   parameter int IDW           = 29,
   parameter bit ACC_FILTER_EN = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           id_vld,
   input  logic [IDW-1:0] id,
   input  logic [IDW-1:0] code,
   input  logic [IDW-1:0] mask,
   input  logic           frame_end,
   output logic           hit
);

   logic match;

   generate
      if (ACC_FILTER_EN) begin : g_mask_cmp
         assign match = (((id ^ code) & ~mask) == '0);
      end else begin : g_pass_all
         assign match = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          hit <= 1'b0;
      else if (frame_end)  hit <= 1'b0;
      else if (id_vld)     hit <= match;
   end

   // R3: a verdict is never present right after a frame end
   AST_HIT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      frame_end |=> !hit); // R3

endmodule

// File: rtl/can_rx_bgbuf.sv
module can_rx_bgbuf
   import can_rx_pkg::*;
#(
   parameter int NBYTES = 13,
   parameter int IDXW   = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [IDXW-1:0]         wr_idx,
   input  byte_t                   wr_data,
   input  logic                    hold,
   output logic [NBYTES-1:0][7:0]  img
);

   logic [NBYTES-1:0][7:0] mem;

   generate
      for (genvar i = 0; i < NBYTES; i++) begin : g_byte
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               mem[i] <= '0;
            else if (wr_en && !hold && (wr_idx == IDXW'(i)))
               mem[i] <= wr_data;
         end
      end
   endgenerate

   assign img = mem;

   // R9: a pending frame image is protected from later captures
   AST_PEND_PROTECT: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> $stable(mem)); // R9

endmodule

// File: rtl/can_rx_fgbuf.sv
module can_rx_fgbuf
   import can_rx_pkg::*;
#(
   parameter int NBYTES = 13,
   parameter int IDXW   = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    load,
   input  logic [NBYTES-1:0][7:0]  load_img,
   input  logic                    full,
   input  logic [IDXW-1:0]         rd_idx,
   output byte_t                   rd_data
);

   logic [NBYTES-1:0][7:0] mem;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    mem <= '0;
      else if (load) mem <= load_img;
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NBYTES; i++) begin
         if (rd_idx == IDXW'(i)) rd_data = mem[i];
      end
   end

   // R6: the readable image is frozen while it is owned by software
   AST_FG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      full |=> $stable(mem)); // R6

endmodule

// File: rtl/can_rx_dualbuf.sv
module can_rx_dualbuf
   import can_rx_pkg::*;
#(
   parameter int NBYTES        = 13,
   parameter int IDW           = 29,
   parameter bit ACC_FILTER_EN = 1'b1,
   localparam int IDXW         = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            rx_wr_en,
   input  logic [IDXW-1:0] rx_wr_idx,
   input  logic [7:0]      rx_wr_data,
   input  logic            rx_id_vld,
   input  logic [IDW-1:0]  rx_id,
   input  logic            rx_eof,
   input  logic            rx_crc_ok,
   input  logic [IDW-1:0]  acc_code,
   input  logic [IDW-1:0]  acc_mask,
   input  logic            rie,
   input  logic            clr_wr,
   input  logic [1:0]      clr_data,
   input  logic [IDXW-1:0] rd_idx,
   output logic [7:0]      rd_data,
   output logic            rxf,
   output logic            ovr,
   output logic            irq
);

   generate
      if (NBYTES < 5 || NBYTES > 64) begin : g_bad_nbytes
         $error("can_rx_dualbuf: NBYTES must be in 5..64");
      end
      if (IDW < 11 || IDW > 29) begin : g_bad_idw
         $error("can_rx_dualbuf: IDW must be in 11..29");
      end
   endgenerate

   logic                   hit;
   logic                   accept;
   logic                   pend_q;
   logic                   rxf_q;
   logic                   ovr_q;
   logic                   promote;
   logic                   fg_load;
   rx_event_e              ev;
   logic [NBYTES-1:0][7:0] bg_img;

   can_rx_accept #(.IDW(IDW), .ACC_FILTER_EN(ACC_FILTER_EN)) u_accept (
      .clk       (clk),
      .rst_n     (rst_n),
      .id_vld    (rx_id_vld),
      .id        (rx_id),
      .code      (acc_code),
      .mask      (acc_mask),
      .frame_end (rx_eof),
      .hit       (hit)
   );

   can_rx_bgbuf #(.NBYTES(NBYTES), .IDXW(IDXW)) u_bg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (rx_wr_en),
      .wr_idx  (rx_wr_idx),
      .wr_data (rx_wr_data),
      .hold    (pend_q),
      .img     (bg_img)
   );

   can_rx_fgbuf #(.NBYTES(NBYTES), .IDXW(IDXW)) u_fg (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (fg_load),
      .load_img (bg_img),
      .full     (rxf_q),
      .rd_idx   (rd_idx),
      .rd_data  (rd_data)
   );

   assign accept = rx_eof & rx_crc_ok & hit;

   always_comb begin
      if (!accept)     ev = EV_NONE;
      else if (pend_q) ev = EV_DROP;
      else if (rxf_q)  ev = EV_PEND;
      else             ev = EV_LOAD;
   end

   assign promote = pend_q & ~rxf_q;
   assign fg_load = promote | (ev == EV_LOAD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         rxf_q  <= 1'b0;
         ovr_q  <= 1'b0;
      end else begin
         if (promote)            pend_q <= 1'b0;
         else if (ev == EV_PEND) pend_q <= 1'b1;

         if (fg_load)                      rxf_q <= 1'b1;
         else if (clr_wr && clr_data[0])   rxf_q <= 1'b0;

         if (ev == EV_DROP)                ovr_q <= 1'b1;
         else if (clr_wr && clr_data[1])   ovr_q <= 1'b0;
      end
   end

   assign rxf = rxf_q;
   assign ovr = ovr_q;
   assign irq = rxf_q & rie;

   // R4: the full flag only rises from a waiting or freshly accepted frame
   AST_RXF_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rxf) |-> $past(pend_q || accept)); // R4
   // R7: without a one in bit 0 of a clear write, the flag stays set
   AST_W0_NOP: assert property (@(posedge clk) disable iff (!rst_n)
      rxf && !(clr_wr && clr_data[0]) |=> rxf); // R7
   // R8: a bad-CRC frame end into an idle store sets nothing
   AST_BAD_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      rx_eof && !rx_crc_ok && !pend_q && !rxf |=> !rxf); // R8
   // R10: overrun only arises while a frame is already waiting
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr) |-> $past(pend_q)); // R10

endmodule

// File: tb/can_rx_dualbuf_bench.sv
module can_rx_dualbuf_bench;

   localparam int CLK_PERIOD = 10;
   localparam int NB         = 13;
   localparam int WATCHDOG   = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_wr_en = 1'b0;
   logic [3:0]  rx_wr_idx = '0;
   logic [7:0]  rx_wr_data = '0;
   logic        rx_id_vld = 1'b0;
   logic [28:0] rx_id = '0;
   logic        rx_eof = 1'b0;
   logic        rx_crc_ok = 1'b0;
   logic [28:0] acc_code = 29'h0ABC_1234;
   logic [28:0] acc_mask = '0;
   logic        rie = 1'b1;
   logic        clr_wr = 1'b0;
   logic [1:0]  clr_data = '0;
   logic [3:0]  rd_idx = '0;
   logic [7:0]  rd_data;
   logic        rxf, ovr, irq;

   can_rx_dualbuf u_can_rx_dualbuf (
      .clk(clk), .rst_n(rst_n), .rx_wr_en(rx_wr_en), .rx_wr_idx(rx_wr_idx),
      .rx_wr_data(rx_wr_data), .rx_id_vld(rx_id_vld), .rx_id(rx_id),
      .rx_eof(rx_eof), .rx_crc_ok(rx_crc_ok), .acc_code(acc_code),
      .acc_mask(acc_mask), .rie(rie), .clr_wr(clr_wr), .clr_data(clr_data),
      .rd_idx(rd_idx), .rd_data(rd_data), .rxf(rxf), .ovr(ovr), .irq(irq)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // behavioural reference state
   logic [7:0] bg_m [NB];
   logic [7:0] fg_m [NB];
   logic       m_rxf, m_ovr, m_pend, m_hit;
   int         n_chk = 0;
   int         n_bad = 0;
   int         cyc = 0;
   string      tag = "R1";

   function automatic void model_reset();
      for (int i = 0; i < NB; i++) begin bg_m[i] = 8'h00; fg_m[i] = 8'h00; end
      m_rxf = 0; m_ovr = 0; m_pend = 0; m_hit = 0;
   endfunction

   // applies one clock edge of the requirements to the model
   function automatic void model_edge();
      logic acc, promote_now, direct, to_pend, drop;
      logic [7:0] snap [NB];
      acc         = rx_eof && rx_crc_ok && m_hit;
      promote_now = m_pend && !m_rxf;
      direct      = acc && !m_pend && !m_rxf;
      to_pend     = acc && !m_pend && m_rxf;
      drop        = acc && m_pend;
      for (int i = 0; i < NB; i++) snap[i] = bg_m[i];
      if (rx_wr_en && !m_pend && int'(rx_wr_idx) < NB) bg_m[rx_wr_idx] = rx_wr_data;
      if (promote_now || direct)
         for (int i = 0; i < NB; i++) fg_m[i] = snap[i];
      if (rx_eof) m_hit = 0;
      else if (rx_id_vld) m_hit = (((rx_id ^ acc_code) & ~acc_mask) == 29'd0);
      if (promote_now || direct) m_rxf = 1;
      else if (clr_wr && clr_data[0]) m_rxf = 0;
      if (drop) m_ovr = 1;
      else if (clr_wr && clr_data[1]) m_ovr = 0;
      if (promote_now) m_pend = 0;
      else if (to_pend) m_pend = 1;
   endfunction

   task automatic chk(input string what, input string req, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s (phase %s) cycle %0d: actual %0h expected %0h",
                  req, what, tag, cyc, act, exp);
      end
   endtask

   // one clock: inputs already set; model follows the edge, outputs compared after it
   task automatic step();
      logic [7:0] exp_rd;
      @(posedge clk);
      if (!rst_n) model_reset(); else model_edge();
      cyc++;
      #2;
      exp_rd = (int'(rd_idx) < NB) ? fg_m[rd_idx] : 8'h00;
      chk("rxf", "R4", int'(rxf), int'(m_rxf));
      chk("ovr", "R10", int'(ovr), int'(m_ovr));
      chk("irq", "R11", int'(irq), int'(m_rxf && rie));
      chk("rd_data", "R5", int'(rd_data), int'(exp_rd));
      rx_wr_en = 0; rx_id_vld = 0; rx_eof = 0; clr_wr = 0; clr_data = '0;
      rd_idx = 4'((cyc * 5) % 16);
   endtask

   task automatic send_frame(input logic [28:0] id, input logic [7:0] base, input logic crc);
      rx_id_vld = 1; rx_id = id;
      step();
      for (int i = 0; i < NB; i++) begin
         rx_wr_en = 1; rx_wr_idx = 4'(i); rx_wr_data = base + 8'(i * 7);
         step();
      end
      rx_eof = 1; rx_crc_ok = crc;
      step();
   endtask

   task automatic sweep(input int n);
      for (int k = 0; k < n; k++) step();
   endtask

   task automatic clear(input logic [1:0] bits);
      clr_wr = 1; clr_data = bits;
      step();
   endtask

   bit done = 0;

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired at cycle %0d (no requirement reached)", cyc);
      finish_run();
   end

   initial begin
      model_reset();
      // R1: reset state
      tag = "R1";
      sweep(3);
      rst_n = 1;
      sweep(16);
      chk("reset rxf", "R1", int'(rxf), 0);

      // R4 / R3: exact identifier match, good CRC, immediate promotion
      tag = "R4";
      send_frame(29'h0ABC_1234, 8'h10, 1'b1);
      sweep(16);

      // R11: interrupt follows enable
      tag = "R11";
      rie = 0; sweep(3); rie = 1; sweep(2);

      // R9 / R6: second frame waits while rxf is set, window stays frozen
      tag = "R9";
      send_frame(29'h0ABC_1234, 8'h40, 1'b1);
      sweep(14);
      // R7: clear write with bit 0 at 0 does nothing
      tag = "R7";
      clear(2'b10);
      sweep(3);
      // R9: clear releases, pending frame promoted next clock
      tag = "R9";
      clear(2'b01);
      sweep(16);

      // R10: third frame while one is pending is dropped, overrun set
      tag = "R10";
      send_frame(29'h0ABC_1234, 8'h70, 1'b1);   // goes pending
      send_frame(29'h0ABC_1234, 8'hA0, 1'b1);   // dropped, ovr
      sweep(4);
      clear(2'b01);                             // promote pending (R9)
      sweep(16);
      clear(2'b10);                             // clear overrun
      sweep(2);
      // R10: set wins over clear in the same cycle
      send_frame(29'h0ABC_1234, 8'h05, 1'b1);   // pending again
      rx_id_vld = 1; rx_id = 29'h0ABC_1234; step();
      rx_eof = 1; rx_crc_ok = 1; clr_wr = 1; clr_data = 2'b10; step();
      sweep(2);
      clear(2'b11);
      sweep(16);
      clear(2'b01);
      sweep(2);

      // R8: bad CRC and rejected identifier leave everything alone
      tag = "R8";
      send_frame(29'h0ABC_1234, 8'h33, 1'b0);
      sweep(3);
      send_frame(29'h0ABC_1235, 8'h55, 1'b1);
      sweep(16);

      // R3: mask makes low bits don't-care
      tag = "R3";
      acc_mask = 29'h0000_00FF;
      send_frame(29'h0ABC_12EE, 8'hC0, 1'b1);
      sweep(16);
      clear(2'b01);
      // R3: eof with no identifier cycle uses the cleared verdict
      rx_eof = 1; rx_crc_ok = 1; step();
      sweep(3);

      // R2: out-of-range capture index ignored, capture invisible until promotion
      tag = "R2";
      for (int i = 13; i < 16; i++) begin
         rx_wr_en = 1; rx_wr_idx = 4'(i); rx_wr_data = 8'hEE; step();
      end
      rx_wr_en = 1; rx_wr_idx = 4'd0; rx_wr_data = 8'h99; step();
      sweep(16);
      rx_id_vld = 1; rx_id = 29'h0ABC_1200; step();
      rx_eof = 1; rx_crc_ok = 1; step();
      sweep(16);

      // R1: reset mid-run returns to idle
      tag = "R1";
      rst_n = 0; sweep(2); rst_n = 1; sweep(16);

      finish_run();
   end

endmodule